// File: doc/BRIEF.md
# Whole-Cache Set/Way Maintenance Walker

This block sweeps an entire 8-way cache by position rather than by address. A single start pulse, with an operation select, starts the walk. The block then emits one maintenance command for every (set, way) pair. Each command is either invalidate or clean-and-invalidate. The cache geometry is not fixed at build time. A size field in the cache-type word gives the bytes per way, and the walker derives the set count from it as bytes per way divided by the 32-byte line. If the presence field of the type word reads zero, no cache exists and the walk finishes at once.

Commands leave on a valid/ready stream. A command counts as transferred on a rising edge where both `cmd_valid_o` and `cmd_ready_i` are high. While valid is high and ready is low, the walker holds its word and its operation code and keeps valid asserted. It never withdraws a command it has offered. Ready may toggle freely. After the last command has been accepted, the walker raises a one-cycle completion barrier and then a one-cycle done pulse. The storage of the cache itself is outside this block.

Top module: `setway_walker`

## Requirements
- R1: Out of reset, `cmd_valid_o`, `barrier_o` and `done_o` are all low, and no two of these three are ever high in the same cycle.
- R2: The cache counts as present when bits 7:3 of `ctype_i` are not all zero. A start with an absent cache pulses `done_o` in the cycle after start, with no command and no barrier.
- R3: For size field f = `ctype_i[11:8]`, the number of sets is (8192 << f) / 32 = 256 << f. A walk issues exactly 8 × (256 << f) commands.
- R4: A command word carries the way index in bits 31:29 and the set index in bits 27:5. Every other bit is zero.
- R5: The walk order is set-major. The first command is set 0, way 0. Within a set, ways ascend 0 to 7, and then the set index increments by one.
- R6: `cmd_op_o` is 0 for invalidate and 1 for clean-and-invalidate. It equals `op_sel_i` as sampled with the accepted start, for every command of that walk.
- R7: While `cmd_valid_o` is high and `cmd_ready_i` is low, the next cycle still offers a command with the same word and operation.
- R8: `barrier_o` pulses for one cycle, in the cycle after the final command is accepted. `done_o` pulses in the cycle after `barrier_o`.
- R9: The type word is captured with the accepted start. Changes to `ctype_i` during the walk do not alter the command count or order.
- R10: A start pulse is ignored from the cycle after an accepted start through the `done_o` cycle. It changes neither the operation nor the command count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| op_sel_i | input | 1 | Operation for the walk: 0 invalidate, 1 clean-and-invalidate |
| ctype_i | input | 32 | Cache-type word: presence in bits 7:3, size field in bits 11:8 |
| cmd_valid_o | output | 1 | A command is offered |
| cmd_ready_i | input | 1 | Downstream accepts the offered command |
| cmd_word_o | output | 32 | Packed set/way word |
| cmd_op_o | output | 1 | Operation code of the offered command |
| barrier_o | output | 1 | One-cycle completion barrier after the last command |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The properties assume that `cmd_ready_i` and `start_i` are driven synchronously and settle before each rising edge. They also assume that ready has no combinational dependence on this block's outputs. The bench changes every input only on falling edges. It applies ready either held high or in a fixed two-of-three pattern. The size-field values are kept small (0 and 1), so that a full sweep, including one under back-pressure, stays short. Start pulses during a walk, and type-word changes during a walk, are placed a few cycles after the accepted start. They therefore land inside the busy window that the properties cover.

// File: rtl/setway_walker_pkg.sv
package setway_walker_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_FENCE = 2'd2,
    ST_FIN   = 2'd3
  } walk_state_e;

  typedef enum logic {
    OP_INV    = 1'b0,
    OP_CLNINV = 1'b1
  } maint_op_e;
endpackage

// File: rtl/sw_geom.sv
// Turns the way-size field into the index of the last set.
module sw_geom #(
  parameter int SIZE_W = 4,
  parameter int SET_W  = 23
) (
  input  logic [SIZE_W-1:0] size_i,
  output logic [SET_W-1:0]  last_set_o
);
  localparam int MAX_SZ = (1 << SIZE_W) - 1;
  logic [SIZE_W-1:0] gap;

  always_comb begin
    gap        = SIZE_W'(MAX_SZ) - size_i;
    last_set_o = {SET_W{1'b1}} >> gap;
  end
endmodule

// File: rtl/sw_index.sv
// Set-major position counter: the way index is the fast digit.
module sw_index #(
  parameter int WAYS  = 8,
  parameter int SET_W = 23,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [SET_W-1:0] last_set_i,
  output logic [SET_W-1:0] set_o,
  output logic [WAY_W-1:0] way_o,
  output logic             at_end_o
);
  logic way_wrap;

  always_comb begin
    way_wrap = (way_o == WAY_W'(WAYS - 1));
    at_end_o = way_wrap && (set_o == last_set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_o <= '0;
      way_o <= '0;
    end else if (clear_i) begin
      set_o <= '0;
      way_o <= '0;
    end else if (step_i) begin
      if (way_wrap) begin
        way_o <= '0;
        set_o <= set_o + SET_W'(1);
      end else begin
        way_o <= way_o + WAY_W'(1);
      end
    end
  end
endmodule

// File: rtl/sw_pack.sv
// Places way and set indices into the command word, zeroing every other bit.
module sw_pack #(
  parameter int WORD_W    = 32,
  parameter int WAY_W     = 3,
  parameter int WAY_POS   = 29,
  parameter int SET_W     = 23,
  parameter int LINE_LOG2 = 5
) (
  input  logic [WAY_W-1:0]  way_i,
  input  logic [SET_W-1:0]  set_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    word_o = '0;
    word_o[WAY_POS +: WAY_W]   = way_i;
    word_o[LINE_LOG2 +: SET_W] = set_i;
  end
endmodule

// File: rtl/setway_walker.sv
module setway_walker
  import setway_walker_pkg::*;
#(
  parameter int WORD_W       = 32,
  parameter int WAYS         = 8,
  parameter int WAY_POS      = 29,
  parameter int LINE_LOG2    = 5,
  parameter int MIN_WAY_LOG2 = 13,
  parameter int SIZE_LSB     = 8,
  parameter int SIZE_W       = 4,
  parameter int PRES_LSB     = 3,
  parameter int PRES_MSB     = 7,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = MIN_WAY_LOG2 - LINE_LOG2 + (1 << SIZE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_sel_i,
  input  logic [31:0]       ctype_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [WORD_W-1:0] cmd_word_o,
  output logic              cmd_op_o,
  output logic              barrier_o,
  output logic              done_o
);
  walk_state_e       state_q;
  logic [SIZE_W-1:0] size_q;
  maint_op_e         op_q;
  logic              present_now;
  logic              take_start;
  logic              step;
  logic              at_end;
  logic [SET_W-1:0]  last_set;
  logic [SET_W-1:0]  set_idx;
  logic [WAY_W-1:0]  way_idx;
  logic              unused_ctype;

  assign unused_ctype = ^{ctype_i[31:SIZE_LSB+SIZE_W], ctype_i[PRES_LSB-1:0]};
  assign present_now  = |ctype_i[PRES_MSB:PRES_LSB];
  assign take_start   = (state_q == ST_IDLE) && start_i;
  assign step         = (state_q == ST_WALK) && cmd_ready_i;

  sw_geom #(.SIZE_W(SIZE_W), .SET_W(SET_W)) u_geom (
    .size_i     (size_q),
    .last_set_o (last_set)
  );

  sw_index #(.WAYS(WAYS), .SET_W(SET_W)) u_index (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (take_start),
    .step_i     (step),
    .last_set_i (last_set),
    .set_o      (set_idx),
    .way_o      (way_idx),
    .at_end_o   (at_end)
  );

  sw_pack #(
    .WORD_W(WORD_W), .WAY_W(WAY_W), .WAY_POS(WAY_POS),
    .SET_W(SET_W), .LINE_LOG2(LINE_LOG2)
  ) u_pack (
    .way_i  (way_idx),
    .set_i  (set_idx),
    .word_o (cmd_word_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      size_q  <= '0;
      op_q    <= OP_INV;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          size_q  <= ctype_i[SIZE_LSB +: SIZE_W];
          op_q    <= maint_op_e'(op_sel_i);
          state_q <= present_now ? ST_WALK : ST_FIN;
        end
        ST_WALK:  if (cmd_ready_i && at_end) state_q <= ST_FENCE;
        ST_FENCE: state_q <= ST_FIN;
        ST_FIN:   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = (state_q == ST_WALK);
  assign barrier_o   = (state_q == ST_FENCE);
  assign done_o      = (state_q == ST_FIN);
  assign cmd_op_o    = op_q;
endmodule

// File: rtl/setway_walker_chk.sv
module setway_walker_chk #(
  parameter int WORD_W    = 32,
  parameter int WAY_W     = 3,
  parameter int WAY_POS   = 29,
  parameter int SET_W     = 23,
  parameter int LINE_LOG2 = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [WORD_W-1:0] cmd_word_o,
  input logic              cmd_op_o,
  input logic              barrier_o,
  input logic              done_o
);
  localparam logic [WORD_W-1:0] WAY_MASK =
    {{(WORD_W-WAY_W){1'b0}}, {WAY_W{1'b1}}} << WAY_POS;
  localparam logic [WORD_W-1:0] SET_MASK =
    {{(WORD_W-SET_W){1'b0}}, {SET_W{1'b1}}} << LINE_LOG2;
  localparam logic [WAY_W-1:0] LAST_WAY = {WAY_W{1'b1}};

  logic [WAY_W-1:0] way_f;
  logic [SET_W-1:0] set_f;
  assign way_f = cmd_word_o[WAY_POS +: WAY_W];
  assign set_f = cmd_word_o[LINE_LOG2 +: SET_W];

  assert_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid_o, barrier_o, done_o}));

  assert_zero_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> ((cmd_word_o & ~(WAY_MASK | SET_MASK)) == '0));

  assert_first_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid_o) |-> (cmd_word_o == '0));

  assert_way_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_ready_i && way_f != LAST_WAY) |=>
      (cmd_valid_o && way_f == WAY_W'($past(way_f) + 1'b1) && set_f == $past(set_f)));

  assert_set_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_ready_i && way_f == LAST_WAY) |=>
      (!cmd_valid_o || (way_f == '0 && set_f == SET_W'($past(set_f) + 1'b1))));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_word_o) && $stable(cmd_op_o)));

  assert_op_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && start_i) |=> (!cmd_valid_o || $stable(cmd_op_o)));

  assert_fence_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    barrier_o |-> $past(cmd_valid_o && cmd_ready_i));

  assert_fence_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    barrier_o |=> (done_o && !barrier_o));
endmodule

bind setway_walker setway_walker_chk #(
  .WORD_W(WORD_W), .WAY_W(WAY_W), .WAY_POS(WAY_POS),
  .SET_W(SET_W), .LINE_LOG2(LINE_LOG2)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_word_o  (cmd_word_o),
  .cmd_op_o    (cmd_op_o),
  .barrier_o   (barrier_o),
  .done_o      (done_o)
);

// File: tb/sim_setway_walker.sv
module sim_setway_walker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        op_sel_i = 1'b0;
  logic [31:0] ctype_i = 32'h0;
  logic        cmd_valid_o;
  logic        cmd_ready_i = 1'b0;
  logic [31:0] cmd_word_o;
  logic        cmd_op_o;
  logic        barrier_o;
  logic        done_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  setway_walker u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_sel_i(op_sel_i),
    .ctype_i(ctype_i), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_word_o(cmd_word_o), .cmd_op_o(cmd_op_o), .barrier_o(barrier_o),
    .done_o(done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected below %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int idx);
    logic [31:0] w = 32'h0;
    w[31:29] = 3'(idx % 8);
    w[27:5]  = 23'(idx / 8);
    return w;
  endfunction

  // R1: reset state
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!cmd_valid_o && !barrier_o && !done_o, "R1", "outputs in reset",
          {cmd_valid_o, barrier_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cmd_valid_o && !barrier_o && !done_o, "R1", "outputs after reset",
          {cmd_valid_o, barrier_o, done_o}, 0);
  endtask

  // R2: absent cache completes with nothing issued
  task automatic t_absent(input logic [31:0] ct);
    int seen_cmd = 0;
    int seen_bar = 0;
    ctype_i = ct;
    cmd_ready_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b1, "R2", "done one cycle after start", done_o, 1);
    for (int k = 0; k < 4; k++) begin
      if (cmd_valid_o) seen_cmd++;
      if (barrier_o) seen_bar++;
      @(negedge clk);
    end
    check(seen_cmd == 0, "R2", "commands when absent", seen_cmd, 0);
    check(seen_bar == 0, "R2", "barrier when absent", seen_bar, 0);
  endtask

  // R3..R10: full walk; mode 1 applies back-pressure; disturb pokes inputs mid-walk
  task automatic t_walk(input logic [31:0] ct, input bit op, input int mode,
                        input bit disturb);
    int n = 0, bad_word = 0, bad_op = 0, bad_hold = 0;
    int bar_cnt = 0, bar_n = -1, bar_cyc = -1, done_cyc = -1, cyc = 0;
    int total = 8 * (256 << ct[11:8]);
    bit stalled = 0;
    logic [31:0] held = 32'h0;
    int first_bad = -1;
    logic [31:0] first_act = 32'h0;
    ctype_i = ct;
    op_sel_i = op;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (cyc < 40000) begin
      if (disturb && cyc == 5) begin
        ctype_i[11:8] = ct[11:8] + 4'd1;
        op_sel_i = ~op;
        start_i = 1'b1;
      end
      if (disturb && cyc == 6) start_i = 1'b0;
      cmd_ready_i = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (stalled && cmd_word_o != held) bad_hold++;
      stalled = 0;
      if (cmd_valid_o) begin
        if (cmd_word_o != exp_word(n)) begin
          if (first_bad < 0) begin first_bad = n; first_act = cmd_word_o; end
          bad_word++;
        end
        if (cmd_op_o != op) bad_op++;
        if (cmd_ready_i) n++;
        else begin stalled = 1; held = cmd_word_o; end
      end
      if (barrier_o) begin bar_cnt++; bar_n = n; bar_cyc = cyc; end
      if (done_o) begin done_cyc = cyc; break; end
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0;
    check(n == total, disturb ? "R9" : "R3", "command count", n, total);
    check(bad_word == 0, "R5", "order/packing (R4) first bad index", first_bad, -1);
    if (first_bad >= 0)
      check(first_act == exp_word(first_bad), "R4", "word at first bad index",
            first_act, exp_word(first_bad));
    check(bad_op == 0, disturb ? "R10" : "R6", "operation mismatches", bad_op, 0);
    check(bar_cnt == 1 && bar_n == total, "R8", "barrier after last command", bar_n, total);
    check(done_cyc == bar_cyc + 1, "R8", "done follows barrier", done_cyc, bar_cyc + 1);
    if (mode != 0)
      check(bad_hold == 0, "R7", "word changed while stalled", bad_hold, 0);
    ctype_i = ct;
    @(negedge clk);
    check(!cmd_valid_o && !done_o && !barrier_o, "R1", "idle after done",
          {cmd_valid_o, barrier_o, done_o}, 0);
  endtask

  initial begin
    t_reset();
    t_absent(32'h0000_0F07);
    t_walk(32'h0000_0008, 1'b0, 0, 1'b0);
    t_walk(32'h0000_0180, 1'b1, 0, 1'b0);
    t_walk(32'h0000_0010, 1'b1, 1, 1'b0);
    t_walk(32'h0000_0040, 1'b0, 1, 1'b1);
    t_absent(32'h0000_0100);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule